// File: doc/BRIEF.md
# SPI Clock Prescaler and Divider Solver

This block turns a requested serial bit rate into the two clock-divider fields that an SPI controller loads to produce it. The controller's bit clock comes from two stages in series: a power-of-two prescaler, chosen by a 2-bit select, followed by a linear divider held in a 6-bit field whose legal values run from 4 to 63. The generated bit clock equals `ref_clk / (2 << presc) / (2 * (lin + 1))`.

Software, or a configuration sequencer, supplies the reference clock frequency and the wanted rate, then pulses `start`. A restoring divider forms `ref_clk / rate` one quotient bit per clock. The block then tries the prescaler steps from the finest to the coarsest. It takes the first step at which the linear stage can reach the rate. A request above the reachable range clamps to the fastest setting. A request below it clamps to the slowest setting.

The packed result is announced with a one-cycle `done` pulse. It then stays unchanged until a later request completes. A request for a zero rate completes at once, with the slowest setting and an error flag.

Top module: `spi_baud_solver`

## Requirements
- R1: `setting` packs the linear divider value in bits [5:0] and the prescaler select in bits [7:6].
- R2: Every delivered setting has a linear value between 4 and 63 and a prescaler select between 0 and 3.
- R3: For a nonzero rate, let q = floor(ref_clk / rate). Prescaler steps are tried in the order 0, 1, 2, 3. At step p the candidate is n = floor(q / (4 << p)). The first step with n <= 64 is chosen, and the linear value is n - 1.
- R4: If the chosen step has n < 5, the rate is too fast. The output is then the chosen step with linear value 4; for ref_clk/rate below 20 this is prescaler 0, linear 4.
- R5: If no step gives n <= 64, the rate is too slow. The output is then prescaler 3 with linear value 63.
- R6: An accepted request with rate 0 raises `done` and `err` on the clock after `start`, with setting 8'hFF (prescaler 3, linear 63).
- R7: An accepted request with a nonzero rate raises `done` for exactly one cycle. This happens RATE_W+1 clocks after the edge that sampled `start`, and `err` is low with it.
- R8: `busy` is high from the clock after an accepted nonzero-rate `start` until the clock that raises `done`. A `start` seen while `busy` is high is ignored.
- R9: `setting` and `err` change only on the clock that raises `done`. They hold their values from then until the next result.
- R10: After reset, `busy`, `done` and `err` are 0, and `setting` is 8'h04 (prescaler 0, linear 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when not busy |
| ref_clk_hz | input | RATE_W | Reference clock frequency feeding the prescaler |
| rate_hz | input | RATE_W | Requested bit rate |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last result came from a zero rate |
| setting | output | 8 | {prescaler select, linear divider value} |

## Verification
Several exact ratios are used to exercise the prescaler search. Quotients of 259 and 260 sit on either side of the step from prescaler 0 to prescaler 1. A quotient of 1000 selects prescaler 2, and 2079 and 2080 both land on the last fit at prescaler 3 and on the saturation beyond it. Rates faster than ref_clk/20, including one above the reference clock, check the fast clamp. Very slow rates and a zero rate separate the ordinary slow clamp from the error path. A second `start` during a division, a request issued in the same cycle as `done`, and input changes with no request show whether the control handshake keeps the result stable.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;

    localparam int PRESC_W   = 2;
    localparam int LIN_W     = 6;
    localparam int LIN_MIN   = 4;
    localparam int LIN_MAX   = (1 << LIN_W) - 1;
    localparam int NUM_STEPS = 1 << PRESC_W;
    localparam int SET_W     = PRESC_W + LIN_W;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [LIN_W-1:0]   lin;
    } brg_set_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_DIVIDE = 1'b1
    } solve_st_t;

    function automatic brg_set_t fastest_set();
        brg_set_t s;
        s.presc = '0;
        s.lin   = LIN_W'(LIN_MIN);
        return s;
    endfunction

    function automatic brg_set_t slowest_set();
        brg_set_t s;
        s.presc = PRESC_W'(NUM_STEPS - 1);
        s.lin   = LIN_W'(LIN_MAX);
        return s;
    endfunction

endpackage

// File: rtl/brg_restoring_div.sv
module brg_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         q_valid
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             valid_q;

    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
        fits    = !trial[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (load) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign q_valid  = valid_q;

    AST_DIV_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> cnt_q != '0); // R7
    AST_DIV_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R7
    AST_DIV_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !run_q); // R8

endmodule

// File: rtl/brg_step_pick.sv
module brg_step_pick
    import spi_brg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] ratio,
    output brg_set_t     pick
);
    logic [W-1:0]     cand  [NUM_STEPS];
    logic [W-1:0]     cand1 [NUM_STEPS];
    logic [NUM_STEPS-1:0] fit;
    logic [NUM_STEPS-1:0] fast;

    for (genvar p = 0; p < NUM_STEPS; p++) begin : g_step
        assign cand[p]  = ratio >> (2 + p);
        assign cand1[p] = cand[p] - W'(1);
        assign fit[p]   = cand[p] <= W'(LIN_MAX + 1);
        assign fast[p]  = cand[p] <  W'(LIN_MIN + 1);
    end

    always_comb begin
        pick = slowest_set();
        for (int p = NUM_STEPS - 1; p >= 0; p--) begin
            if (fit[p]) begin
                pick.presc = PRESC_W'(p);
                pick.lin   = fast[p] ? LIN_W'(LIN_MIN) : cand1[p][LIN_W-1:0];
            end
        end
    end

endmodule

// File: rtl/brg_solve_ctrl.sv
module brg_solve_ctrl
    import spi_brg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] rate_hz,
    input  logic         q_valid,
    input  brg_set_t     pick,
    output logic         div_load,
    output logic         busy,
    output logic         done,
    output logic         err,
    output brg_set_t     setting
);
    solve_st_t state_q;
    logic      done_q;
    logic      err_q;
    brg_set_t  set_q;
    logic      zero_rate;

    assign zero_rate = (rate_hz == '0);
    assign div_load  = (state_q == ST_IDLE) && start && !zero_rate;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            set_q   <= fastest_set();
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (zero_rate) begin
                            set_q  <= slowest_set();
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_DIVIDE;
                        end
                    end
                end
                ST_DIVIDE: begin
                    if (q_valid) begin
                        set_q   <= pick;
                        err_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == ST_DIVIDE);
    assign done    = done_q;
    assign err     = err_q;
    assign setting = set_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7
    AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> ($stable(set_q) && $stable(err_q))); // R9
    AST_LIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        done_q |-> set_q.lin >= LIN_W'(LIN_MIN)); // R2
    AST_ERR_SLOWEST: assert property (@(posedge clk) disable iff (rst)
        (done_q && err_q) |-> set_q == slowest_set()); // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !q_valid) |=> busy); // R8
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done_q); // R8

endmodule

// File: rtl/spi_baud_solver.sv
module spi_baud_solver
    import spi_brg_pkg::*;
#(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] ref_clk_hz,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [SET_W-1:0]  setting
);
    logic              div_load;
    logic [RATE_W-1:0] ratio;
    logic              q_valid;
    brg_set_t          pick;
    brg_set_t          set_s;

    brg_restoring_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .dividend (ref_clk_hz),
        .divisor  (rate_hz),
        .quotient (ratio),
        .q_valid  (q_valid)
    );

    brg_step_pick #(.W(RATE_W)) u_pick (
        .ratio (ratio),
        .pick  (pick)
    );

    brg_solve_ctrl #(.W(RATE_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rate_hz  (rate_hz),
        .q_valid  (q_valid),
        .pick     (pick),
        .div_load (div_load),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .setting  (set_s)
    );

    assign setting = set_s;

endmodule

// File: tb/sim_spi_baud_solver.sv
module sim_spi_baud_solver;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] ref_clk_hz = '0;
    logic [W-1:0] rate_hz = '0;
    logic         busy, done, err;
    logic [7:0]   setting;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    spi_baud_solver #(.RATE_W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .ref_clk_hz(ref_clk_hz),
        .rate_hz(rate_hz), .busy(busy), .done(done), .err(err), .setting(setting)
    );

    function automatic logic [7:0] ref_set(longint fin, longint r);
        longint q, n;
        q = fin / r;
        for (int d = 0; d < 4; d++) begin
            n = q / (longint'(4) << d);
            if (n < 5) return {2'(d), 6'd4};
            if (n <= 64) return {2'(d), 6'(n - 1)};
        end
        return 8'hFF;
    endfunction

    // behavioural model, advanced on every rising edge
    logic       m_busy = 1'b0, m_done = 1'b0, m_err = 1'b0;
    logic [7:0] m_set = 8'h04, m_pend = 8'h00;
    int         m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_err = 1'b0; m_set = 8'h04; m_cnt = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_set = m_pend; m_err = 1'b0;
                end
            end else if (start) begin
                if (rate_hz == 0) begin
                    m_done = 1'b1; m_set = 8'hFF; m_err = 1'b1;
                end else begin
                    m_pend = ref_set(longint'(ref_clk_hz), longint'(rate_hz));
                    m_busy = 1'b1; m_cnt = W + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk(done == m_done, "R7 done", done, m_done);
            chk(busy == m_busy, "R8 busy", busy, m_busy);
            chk(setting == m_set, "R9 setting", setting, m_set);
            chk(err == m_err, "R6 err", err, m_err);
        end
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic pulse(input longint fin, input longint r);
        @(negedge clk);
        ref_clk_hz = W'(fin); rate_hz = W'(r); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    endtask

    task automatic run_case(input longint fin, input longint r, input logic [7:0] exp,
                            input logic exp_err, input string req);
        pulse(fin, r);
        if (!done) wait_done();
        chk(done == 1'b1, req, done, 1);
        chk(setting == exp, req, setting, exp);
        chk(err == exp_err, req, err, exp_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(busy == 0 && done == 0 && err == 0, "R10", {busy, done, err}, 0);
        chk(setting == 8'h04, "R10", setting, 8'h04);

        // R6 zero rate: done on the clock after start
        run_case(100_000_000, 0, 8'hFF, 1'b1, "R6");
        // R4 boundary q=20 and rate above ref clock
        run_case(100_000_000, 5_000_000, 8'h04, 1'b0, "R4");
        run_case(1_000, 200_000, 8'h04, 1'b0, "R4");
        // R3 step edges
        run_case(259_000, 1_000, {2'd0, 6'd63}, 1'b0, "R3");
        run_case(260_000, 1_000, {2'd1, 6'd31}, 1'b0, "R3");
        run_case(100_000_000, 1_000_000, {2'd0, 6'd24}, 1'b0, "R3");
        run_case(2_079_000, 1_000, {2'd3, 6'd63}, 1'b0, "R3");
        // R1 field layout: prescaler 2, linear 61
        run_case(100_000_000, 100_000, {2'd2, 6'd61}, 1'b0, "R1");
        chk(setting[7:6] == 2'd2, "R1 presc", setting[7:6], 2);
        chk(setting[5:0] == 6'd61, "R1 lin", setting[5:0], 61);
        // R5 slow clamp
        run_case(2_080_000, 1_000, 8'hFF, 1'b0, "R5");
        run_case(100_000_000, 10_000, 8'hFF, 1'b0, "R5");
        run_case(32'hFFFF_FFFF, 1, 8'hFF, 1'b0, "R5");
        // R2 range
        chk(setting[5:0] >= 6'd4, "R2", setting[5:0], 4);

        // R8: a zero-rate start during a division is ignored
        pulse(100_000_000, 1_000_000);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R8 busy", busy, 1);
        ref_clk_hz = 0; rate_hz = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(setting == {2'd0, 6'd24} && err == 1'b0, "R8 ignore", {err, setting}, {1'b0, 2'd0, 6'd24});

        // R7: a request issued in the cycle that shows done is accepted
        ref_clk_hz = 260_000; rate_hz = 1_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 back-to-back", busy, 1);
        wait_done();
        chk(setting == {2'd1, 6'd31}, "R7 back-to-back", setting, {2'd1, 6'd31});

        // R9: inputs move, no start, result holds
        ref_clk_hz = 5; rate_hz = 0;
        repeat (10) @(negedge clk);
        chk(setting == {2'd1, 6'd31} && !err && !done, "R9 hold", setting, {2'd1, 6'd31});

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule